// File: doc/BRIEF.md
# Code Memory Lock Protection Unit

This unit keeps three lock bits for an on-chip code memory and turns them into the permission signals the memory subsystem consults: whether the array may still be programmed, whether its contents may be read back for verification, whether code may run from external memory, and whether table-read instructions running from external code may fetch bytes from the internal array. The lock bits only move toward the programmed state through a program-lock command. They return to the unprogrammed state only through a chip-erase command. A reset does not disturb them, because they model non-volatile storage.

Protection is cumulative. Each programmed bit adds its restriction on top of those of the lower bits. A combination that skips a bit is treated as the strictest level its highest programmed bit implies. Whenever any protection is active, the level of the external-access pin is captured while reset is asserted. After reset, the unit compares that captured level with the live pin and raises a fault flag when the two differ.

The lock bits can always be read back directly, whatever the protection level. The level of the external-access pin held before the first reset is undefined, and `ea_valid` is meaningful only after the first reset.

Top module: `lockp_unit`

## Requirements
- R1: `lock_bits` always shows the stored lock bits, whatever the protection level. Bit 0 is the first lock bit, bit 1 the second and bit 2 the third, and a 1 means programmed.
- R2: In a clock cycle with `rst` low, `prog_req` high and `erase_req` low, the stored bits become their previous value ORed with `prog_mask`, visible after that clock edge. No command other than an erase ever turns a programmed bit back to unprogrammed.
- R3: In a clock cycle with `rst` low and `erase_req` high, all stored bits become 0 after the edge. This holds even when `prog_req` is high in the same cycle: erase wins.
- R4: While `rst` is high, `prog_req` and `erase_req` are ignored and the stored bits keep their value.
- R5: Asserting `rst` does not change the stored lock bits.
- R6: `prot_level` is 0 when no bit is programmed. Otherwise it is one plus the index of the highest programmed bit: 1 for the first bit alone, 2 when the second bit is the highest, 3 when the third bit is programmed.
- R7: `prog_ok` and `tbl_fetch_ok` are high exactly when no lock bit is programmed.
- R8: `verify_ok` is low exactly when the second or third bit is programmed. `ext_exec_ok` is low exactly when the third bit is programmed.
- R9: On every clock edge with `rst` high, `ea_latched` takes the level of `ea_pin`. `ea_valid` becomes 1 if any lock bit is programmed and 0 otherwise.
- R10: `ea_fault` is high, combinationally, exactly when `rst` is low, `ea_valid` is 1, at least one lock bit is programmed, and `ea_latched` differs from `ea_pin`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also the capture window for the external-access level |
| prog_req | input | 1 | Program-lock command |
| prog_mask | input | 3 | Bits to program with the command |
| erase_req | input | 1 | Chip-erase command; clears all lock bits |
| ea_pin | input | 1 | Live external-access pin level |
| lock_bits | output | 3 | Stored lock bits, read back directly |
| prot_level | output | 2 | Effective protection level, 0 to 3 |
| prog_ok | output | 1 | Array programming permitted |
| verify_ok | output | 1 | Read-back for verification permitted |
| ext_exec_ok | output | 1 | Execution from external code memory permitted |
| tbl_fetch_ok | output | 1 | Table reads from external code may fetch internal bytes |
| ea_latched | output | 1 | External-access level captured during reset |
| ea_valid | output | 1 | The captured level is in force, because protection was active at reset |
| ea_fault | output | 1 | Captured and live external-access levels disagree |

## Verification
Two collisions matter most. The first is an erase and a program-lock command arriving in the same cycle. The bench provokes it directly and also through random stimulus, and judges it by `lock_bits` reading zero after the edge. The second is a reset cycle that coincides with a command or with a change of the external-access pin. The bench checks that the command left the bits untouched, that the pin level present at the edge was captured, and that the fault flag follows the live pin once reset is released.

// File: rtl/lockp_pkg.sv
`timescale 1ns/1ps
package lockp_pkg;

    localparam int LOCK_W  = 3;
    localparam int LEVEL_W = $clog2(LOCK_W + 1);

    // protection thresholds (levels at which a right is withdrawn)
    localparam int LVL_NO_PROG   = 1;
    localparam int LVL_NO_VERIFY = 2;
    localparam int LVL_NO_EXT    = 3;

    typedef logic [LOCK_W-1:0]  lock_vec_t;
    typedef logic [LEVEL_W-1:0] level_t;

    typedef struct packed {
        logic      erase;
        logic      prog;
        lock_vec_t mask;
    } lock_cmd_t;

    typedef struct packed {
        logic prog_ok;
        logic verify_ok;
        logic ext_exec_ok;
        logic tbl_fetch_ok;
    } perm_t;

    // highest programmed bit sets the level: cumulative protection
    function automatic level_t lock_level(input lock_vec_t bits);
        level_t lvl;
        lvl = '0;
        for (int i = 0; i < LOCK_W; i++) begin
            if (bits[i]) lvl = level_t'(i + 1);
        end
        return lvl;
    endfunction

    function automatic perm_t level_perms(input level_t lvl);
        perm_t p;
        p.prog_ok      = (int'(lvl) < LVL_NO_PROG);
        p.tbl_fetch_ok = (int'(lvl) < LVL_NO_PROG);
        p.verify_ok    = (int'(lvl) < LVL_NO_VERIFY);
        p.ext_exec_ok  = (int'(lvl) < LVL_NO_EXT);
        return p;
    endfunction

endpackage

// File: rtl/lockp_bits.sv
`timescale 1ns/1ps
module lockp_bits
    import lockp_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  lock_cmd_t cmd,
    output lock_vec_t bits_q
);
    // Non-volatile model: reset does not clear the bits, and commands wait for reset release.
    lock_vec_t bits_d;

    always_comb begin
        bits_d = bits_q;
        if (cmd.erase)     bits_d = '0;
        else if (cmd.prog) bits_d = bits_q | cmd.mask;
    end

    always_ff @(posedge clk) begin
        if (!rst) bits_q <= bits_d;
    end
endmodule

// File: rtl/lockp_decode.sv
`timescale 1ns/1ps
module lockp_decode
    import lockp_pkg::*;
(
    input  lock_vec_t bits,
    output level_t    level,
    output perm_t     perm
);
    always_comb begin
        level = lock_level(bits);
        perm  = level_perms(level);
    end
endmodule

// File: rtl/lockp_ea_latch.sv
`timescale 1ns/1ps
module lockp_ea_latch (
    input  logic clk,
    input  logic rst,
    input  logic armed,
    input  logic ea_pin,
    output logic ea_latched,
    output logic ea_valid,
    output logic ea_fault
);
    // Capture happens only in reset cycles; before the first reset the level is undefined.
    always_ff @(posedge clk) begin
        if (rst) begin
            ea_latched <= ea_pin;
            ea_valid   <= armed;
        end
    end

    always_comb begin
        ea_fault = !rst && ea_valid && armed && (ea_latched != ea_pin);
    end
endmodule

// File: rtl/lockp_unit.sv
`timescale 1ns/1ps
module lockp_unit
    import lockp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              prog_req,
    input  logic [LOCK_W-1:0] prog_mask,
    input  logic              erase_req,
    input  logic              ea_pin,
    output logic [LOCK_W-1:0] lock_bits,
    output logic [LEVEL_W-1:0] prot_level,
    output logic              prog_ok,
    output logic              verify_ok,
    output logic              ext_exec_ok,
    output logic              tbl_fetch_ok,
    output logic              ea_latched,
    output logic              ea_valid,
    output logic              ea_fault
);
    lock_cmd_t cmd;
    lock_vec_t bits_q;
    level_t    level;
    perm_t     perm;

    always_comb begin
        cmd.erase = erase_req;
        cmd.prog  = prog_req;
        cmd.mask  = prog_mask;
    end

    lockp_bits u_bits (
        .clk    (clk),
        .rst    (rst),
        .cmd    (cmd),
        .bits_q (bits_q)
    );

    lockp_decode u_dec (
        .bits  (bits_q),
        .level (level),
        .perm  (perm)
    );

    lockp_ea_latch u_ea (
        .clk        (clk),
        .rst        (rst),
        .armed      (level != '0),
        .ea_pin     (ea_pin),
        .ea_latched (ea_latched),
        .ea_valid   (ea_valid),
        .ea_fault   (ea_fault)
    );

    always_comb begin
        lock_bits    = bits_q;
        prot_level   = level;
        prog_ok      = perm.prog_ok;
        verify_ok    = perm.verify_ok;
        ext_exec_ok  = perm.ext_exec_ok;
        tbl_fetch_ok = perm.tbl_fetch_ok;
    end
endmodule

// File: rtl/lockp_checker.sv
`timescale 1ns/1ps
module lockp_checker
    import lockp_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              prog_req,
    input logic [LOCK_W-1:0] prog_mask,
    input logic              erase_req,
    input logic              ea_pin,
    input logic [LOCK_W-1:0] lock_bits,
    input logic [LEVEL_W-1:0] prot_level,
    input logic              prog_ok,
    input logic              verify_ok,
    input logic              ext_exec_ok,
    input logic              tbl_fetch_ok,
    input logic              ea_latched,
    input logic              ea_valid,
    input logic              ea_fault
);
    // R2: without erase, programmed bits stay programmed
    a_r2_monotonic: assert property (@(posedge clk) disable iff (rst)
        !erase_req |=> ((lock_bits & $past(lock_bits)) == $past(lock_bits)));

    // R2: requested bits are programmed after the edge
    a_r2_prog_sets: assert property (@(posedge clk) disable iff (rst)
        (prog_req && !erase_req) |=> ((lock_bits & $past(prog_mask)) == $past(prog_mask)));

    // R3: erase clears everything, even alongside a program command
    a_r3_erase_clears: assert property (@(posedge clk) disable iff (rst)
        erase_req |=> (lock_bits == '0));

    // R7: programming and table fetch rights are withdrawn together
    a_r7_prog_tbl_pair: assert property (@(posedge clk) disable iff (rst)
        prog_ok == tbl_fetch_ok);

    // R8: restrictions nest: no external execution implies no verify implies no programming
    a_r8_nested: assert property (@(posedge clk) disable iff (rst)
        (!ext_exec_ok |-> !verify_ok) and (!verify_ok |-> !prog_ok));

    // R10: a fault needs a captured level and active protection
    a_r10_fault_needs_capture: assert property (@(posedge clk) disable iff (rst)
        ea_fault |-> (ea_valid && !prog_ok));

    // R10: captured level and live pin agree whenever no fault is flagged under protection
    a_r10_agree: assert property (@(posedge clk) disable iff (rst)
        (ea_valid && !prog_ok && !ea_fault) |-> (ea_latched == ea_pin));
endmodule

bind lockp_unit lockp_checker u_chk (.*);

// File: tb/tb_lockp_unit.sv
`timescale 1ns/1ps
module tb_lockp_unit;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       prog_req = 1'b0;
    logic [2:0] prog_mask = '0;
    logic       erase_req = 1'b0;
    logic       ea_pin = 1'b0;
    logic [2:0] lock_bits;
    logic [1:0] prot_level;
    logic       prog_ok, verify_ok, ext_exec_ok, tbl_fetch_ok;
    logic       ea_latched, ea_valid, ea_fault;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference model state
    logic [2:0] m_bits = '0;
    logic       m_lat = 1'b0;
    logic       m_valid = 1'b0;
    bit         bits_known = 0;
    bit         known = 0;

    always #4 clk = ~clk;

    lockp_unit dut (.*);

    function automatic logic [1:0] exp_level(input logic [2:0] b);
        logic [1:0] l;
        l = 2'd0;
        for (int i = 0; i < 3; i++) if (b[i]) l = 2'(i + 1);
        return l;
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic check_all();
        logic [1:0] l;
        l = exp_level(m_bits);
        check("R1", "lock_bits", 32'(lock_bits), 32'(m_bits));
        check("R6", "prot_level", 32'(prot_level), 32'(l));
        check("R7", "prog_ok", 32'(prog_ok), 32'(l == 0));
        check("R7", "tbl_fetch_ok", 32'(tbl_fetch_ok), 32'(l == 0));
        check("R8", "verify_ok", 32'(verify_ok), 32'(!(m_bits[1] || m_bits[2])));
        check("R8", "ext_exec_ok", 32'(ext_exec_ok), 32'(!m_bits[2]));
        check("R9", "ea_valid", 32'(ea_valid), 32'(m_valid));
        if (m_valid) check("R9", "ea_latched", 32'(ea_latched), 32'(m_lat));
        check("R10", "ea_fault", 32'(ea_fault),
              32'(!rst && m_valid && (m_bits != 0) && (m_lat != ea_pin)));
    endtask

    // drive at negedge, update the model at posedge, check just after
    task automatic step(input logic r, input logic p, input logic [2:0] m,
                        input logic e, input logic pin);
        @(negedge clk);
        rst = r; prog_req = p; prog_mask = m; erase_req = e; ea_pin = pin;
        @(posedge clk);
        if (r) begin
            m_lat   = pin;
            m_valid = (m_bits != 0);
            if (bits_known) known = 1;
        end else if (e) begin
            m_bits = '0;
            bits_known = 1;
        end else if (p) begin
            m_bits = m_bits | m;
        end
        #1;
        if (known) check_all();
    endtask

    initial begin
        #(8 * 100000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic pin;
        void'($urandom(32'd20240611));
        step(1, 0, 0, 0, 0);
        step(1, 0, 0, 0, 0);
        step(0, 0, 0, 1, 0);          // establish erased bits
        step(1, 0, 0, 0, 0);          // reset state: all rights granted, no capture
        step(0, 0, 0, 0, 0);

        // R4: commands during reset ignored
        step(1, 1, 3'b111, 0, 0);
        step(1, 0, 0, 1, 0);
        step(0, 0, 0, 0, 0);

        // R3: erase beats program in the same cycle
        step(0, 1, 3'b011, 0, 0);
        step(0, 1, 3'b100, 1, 0);
        check("R3", "erase wins", 32'(lock_bits), 32'd0);

        // R6/R7/R8: every bit combination, including skipped bits
        for (int k = 0; k < 8; k++) begin
            step(0, 0, 0, 1, 0);
            step(0, 1, 3'(k), 0, 0);
        end

        // R2: bits accumulate and never clear without erase
        step(0, 0, 0, 1, 0);
        step(0, 1, 3'b100, 0, 0);
        step(0, 1, 3'b001, 0, 0);
        step(0, 1, 3'b000, 0, 0);
        check("R2", "accumulated", 32'(lock_bits), 32'b101);

        // R5/R9/R10: capture under protection, then mismatch
        step(0, 0, 0, 1, 0);
        step(0, 1, 3'b001, 0, 0);
        step(1, 0, 0, 0, 1);
        check("R5", "bits kept over reset", 32'(lock_bits), 32'b001);
        step(0, 0, 0, 0, 1);
        step(0, 0, 0, 0, 0);
        check("R10", "mismatch flagged", 32'(ea_fault), 32'd1);
        step(0, 0, 0, 0, 1);
        step(0, 0, 0, 1, 0);
        check("R10", "no fault once erased", 32'(ea_fault), 32'd0);
        step(1, 0, 0, 0, 1);
        check("R9", "no capture without protection", 32'(ea_valid), 32'd0);

        // random mix
        pin = 1'b0;
        for (int n = 0; n < 3000; n++) begin
            int op;
            op = int'($urandom % 16);
            if ($urandom % 8 == 0) pin = ~pin;
            step(op == 0, op >= 3 && op < 9, 3'($urandom % 8), op == 1 || op == 3, pin);
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule